// File: doc/BRIEF.md
# Residue and Parity Checked ALU

This block is a 16-bit arithmetic and logic unit that checks its own result in the same cycle it computes it. Every operation belongs to one of four classes. Arithmetic operations (add, subtract, multiply) are guarded by a modulo-15 residue. Bitwise logic, logical shifts and rotates are guarded by an even-parity bit that is predicted from the operands. A prediction path works from the operands alone and runs alongside the datapath. A second generator re-derives the same check value from the produced result. Any disagreement is captured as an error flag in the same register stage that captures the result.

The result port is twice the operand width. It carries the full product of a multiply, the carry of an add, and a borrow-extended difference for a subtract. A fault-injection input flips chosen result bits before they are checked and registered. It lets a surrounding system, or a test, model an upset in the datapath. A qualifying valid input decides whether a cycle carries an operation. Idle cycles keep the last result and never raise the flag. Opcode values outside the defined set give a zero result with no error.

Top module: `resparity_alu`

## Requirements
- R1: Opcodes 0, 1 and 2 select add, subtract and multiply. One clock edge after a cycle with `op_valid` high, `result_q` holds: for add, the 17-bit sum zero-extended; for subtract, the 16-bit difference with bits 31:16 all equal to the borrow (a < b); for multiply, the full 32-bit product. `valid_q` follows `op_valid` with one cycle of delay.
- R2: Opcodes 3, 4 and 5 select AND, OR and XOR of the operands, zero-extended to 32 bits.
- R3: Opcodes 6 and 7 select a left or right logical shift of `opd_a` by `opd_b[3:0]`, filling with zeros, zero-extended to 32 bits.
- R4: Opcodes 8 and 9 select a left or right rotate of `opd_a` by `opd_b[3:0]` within 16 bits, zero-extended to 32 bits.
- R5: With `inj_flip` zero, a valid operation with any opcode from 0 to 9 leaves `err_q` low, for any operands.
- R6: For opcodes 0 to 2, flipping any single bit of the 32-bit result through `inj_flip` sets `err_q` high one cycle later. `result_q` shows the flipped value.
- R7: For opcodes 3 to 9, flipping any single bit of the 32-bit result through `inj_flip` sets `err_q` high one cycle later. `result_q` shows the flipped value.
- R8: In a cycle after one with `op_valid` low, `err_q` and `valid_q` are low and `result_q` keeps its previous value, whatever `inj_flip` holds.
- R9: Opcodes 10 to 15 give a `result_q` of zero and a low `err_q`, even when `inj_flip` is nonzero.
- R10: While `rst_n` is low, `result_q`, `err_q` and `valid_q` are zero.
- R11: A residue of 15 and a residue of 0 compare as equal. An add of 0x0005 and 0x000A gives 0x0000000F with `err_q` low, and an add of 0xFFFF and 0x0001 gives 0x00010000 with `err_q` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | The current cycle carries an operation |
| opcode | input | 4 | Operation select, encoding given in R1 to R4 and R9 |
| opd_a | input | 16 | First operand; the shifted or rotated value |
| opd_b | input | 16 | Second operand; bits 3:0 give the shift or rotate amount |
| inj_flip | input | 32 | Result bits to invert before checking (fault model) |
| result_q | output | 32 | Registered result |
| err_q | output | 1 | Registered check mismatch |
| valid_q | output | 1 | Registered copy of op_valid |

## Verification
The result capture and the error capture share one clock edge. A corrupted result must therefore show up in `result_q` and `err_q` in the same cycle. The bench issues every defined opcode with each of the 32 single-bit flips applied in the same cycle as the operation. It then requires that the registered result equals the arithmetic expectation XOR the flip, and that the flag is set in that same cycle. It also holds `inj_flip` nonzero during idle cycles and during illegal opcodes, and judges that neither path lets the flip reach the flag or the held result.

// File: rtl/resparity_alu_pkg.sv
package resparity_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_SLL = 4'd6,
        OP_SRL = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9
    } alu_op_e;

    typedef enum logic [2:0] {
        GRP_NONE  = 3'd0,
        GRP_ARITH = 3'd1,
        GRP_LOGIC = 3'd2,
        GRP_SHIFT = 3'd3,
        GRP_ROT   = 3'd4
    } chk_grp_e;

    // Reduce an 8-bit value modulo 15 by folding nibbles; 15 maps to 0.
    function automatic logic [3:0] res_fold(input logic [7:0] val);
        logic [4:0] part;
        logic [3:0] red;
        part = {1'b0, val[3:0]} + {1'b0, val[7:4]};
        red  = part[3:0] + {3'b000, part[4]};
        return (red == 4'hF) ? 4'h0 : red;
    endfunction

endpackage

// File: rtl/resparity_alu_residue.sv
module resparity_alu_residue
    import resparity_alu_pkg::*;
#(
    parameter  int WORD_W = 32,
    localparam int NIB_N  = WORD_W / 4,
    localparam int SUM_W  = $clog2(15 * NIB_N + 1)
) (
    input  logic [WORD_W-1:0] word,
    output logic [3:0]        res
);

    logic [NIB_N-1:0][3:0] nib;
    logic [SUM_W-1:0]      nib_sum;

    for (genvar g = 0; g < NIB_N; g++) begin : g_nib
        assign nib[g] = word[4*g +: 4];
    end

    always_comb begin
        nib_sum = '0;
        for (int i = 0; i < NIB_N; i++) begin
            nib_sum = nib_sum + SUM_W'(nib[i]);
        end
        res = res_fold(8'(nib_sum));
    end

endmodule

// File: rtl/resparity_alu_exec.sv
module resparity_alu_exec
    import resparity_alu_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int RES_W  = 2 * DATA_W,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    output logic [RES_W-1:0]  raw_res,
    output logic              legal
);

    logic [DATA_W:0]   wide;
    logic [RES_W-1:0]  dbl;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] zpad;

    assign sh   = opd_b[SH_W-1:0];
    assign zpad = '0;

    always_comb begin
        raw_res = '0;
        legal   = 1'b1;
        wide    = '0;
        dbl     = '0;
        case (opcode)
            OP_ADD: begin
                wide    = {1'b0, opd_a} + {1'b0, opd_b};
                raw_res = {{(DATA_W-1){1'b0}}, wide};
            end
            OP_SUB: begin
                wide    = {1'b0, opd_a} - {1'b0, opd_b};
                raw_res = {{DATA_W{wide[DATA_W]}}, wide[DATA_W-1:0]};
            end
            OP_MUL: raw_res = {zpad, opd_a} * {zpad, opd_b};
            OP_AND: raw_res = {zpad, opd_a & opd_b};
            OP_OR:  raw_res = {zpad, opd_a | opd_b};
            OP_XOR: raw_res = {zpad, opd_a ^ opd_b};
            OP_SLL: raw_res = {zpad, opd_a << sh};
            OP_SRL: raw_res = {zpad, opd_a >> sh};
            OP_ROL: begin
                dbl     = {opd_a, opd_a} << sh;
                raw_res = {zpad, dbl[RES_W-1:DATA_W]};
            end
            OP_ROR: begin
                dbl     = {opd_a, opd_a} >> sh;
                raw_res = {zpad, dbl[DATA_W-1:0]};
            end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/resparity_alu_predict.sv
module resparity_alu_predict
    import resparity_alu_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    output chk_grp_e          grp,
    output logic [3:0]        pred_res,
    output logic              pred_par
);

    logic [3:0]        res_a;
    logic [3:0]        res_b;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] ones;
    logic [DATA_W-1:0] and_v;
    logic [DATA_W-1:0] lost;
    logic              par_a;
    logic              par_b;
    logic              borrow;

    resparity_alu_residue #(.WORD_W(DATA_W)) u_res_a (.word(opd_a), .res(res_a));
    resparity_alu_residue #(.WORD_W(DATA_W)) u_res_b (.word(opd_b), .res(res_b));

    assign sh     = opd_b[SH_W-1:0];
    assign ones   = '1;
    assign and_v  = opd_a & opd_b;
    assign par_a  = ^opd_a;
    assign par_b  = ^opd_b;
    assign borrow = (opd_a < opd_b);

    always_comb begin
        grp      = GRP_NONE;
        pred_res = 4'h0;
        pred_par = 1'b0;
        lost     = '0;
        case (opcode)
            OP_ADD: begin
                grp      = GRP_ARITH;
                pred_res = res_fold({4'h0, res_a} + {4'h0, res_b});
            end
            OP_SUB: begin
                grp      = GRP_ARITH;
                pred_res = res_fold({4'h0, res_a} + {4'h0, 4'hF - res_b} + {7'h00, borrow});
            end
            OP_MUL: begin
                grp      = GRP_ARITH;
                pred_res = res_fold({4'h0, res_a} * {4'h0, res_b});
            end
            OP_AND: begin
                grp      = GRP_LOGIC;
                pred_par = ^and_v;
            end
            OP_OR: begin
                grp      = GRP_LOGIC;
                pred_par = par_a ^ par_b ^ (^and_v);
            end
            OP_XOR: begin
                grp      = GRP_LOGIC;
                pred_par = par_a ^ par_b;
            end
            OP_SLL: begin
                grp      = GRP_SHIFT;
                lost     = opd_a & ~(ones >> sh);
                pred_par = par_a ^ (^lost);
            end
            OP_SRL: begin
                grp      = GRP_SHIFT;
                lost     = opd_a & ~(ones << sh);
                pred_par = par_a ^ (^lost);
            end
            OP_ROL, OP_ROR: begin
                grp      = GRP_ROT;
                pred_par = par_a;
            end
            default: grp = GRP_NONE;
        endcase
    end

endmodule

// File: rtl/resparity_alu.sv
module resparity_alu
    import resparity_alu_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int RES_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic [RES_W-1:0]  inj_flip,
    output logic [RES_W-1:0]  result_q,
    output logic              err_q,
    output logic              valid_q
);

    typedef struct packed {
        logic [RES_W-1:0] result;
        logic             err;
        logic             valid;
    } alu_state_t;

    alu_state_t       st_d;
    alu_state_t       st_q;
    logic [RES_W-1:0] raw_res;
    logic [RES_W-1:0] obs_res;
    logic             legal;
    chk_grp_e         grp;
    logic [3:0]       pred_res;
    logic             pred_par;
    logic [3:0]       out_res;
    logic             out_par;
    logic             mismatch;

    resparity_alu_exec #(.DATA_W(DATA_W)) u_exec (
        .opcode (opcode),
        .opd_a  (opd_a),
        .opd_b  (opd_b),
        .raw_res(raw_res),
        .legal  (legal)
    );

    resparity_alu_predict #(.DATA_W(DATA_W)) u_predict (
        .opcode  (opcode),
        .opd_a   (opd_a),
        .opd_b   (opd_b),
        .grp     (grp),
        .pred_res(pred_res),
        .pred_par(pred_par)
    );

    // Fault model: selected result bits are inverted before the check.
    assign obs_res = legal ? (raw_res ^ inj_flip) : '0;

    resparity_alu_residue #(.WORD_W(RES_W)) u_res_out (.word(obs_res), .res(out_res));

    assign out_par = ^obs_res;

    always_comb begin
        case (grp)
            GRP_ARITH:                     mismatch = (out_res != pred_res);
            GRP_LOGIC, GRP_SHIFT, GRP_ROT: mismatch = (out_par != pred_par);
            default:                       mismatch = 1'b0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        st_d.err   = 1'b0;
        if (op_valid) begin
            st_d.result = obs_res;
            st_d.err    = mismatch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_q = st_q.result;
    assign err_q    = st_q.err;
    assign valid_q  = st_q.valid;

endmodule

// File: rtl/resparity_alu_chk.sv
module resparity_alu_chk #(
    parameter  int DATA_W = 16,
    localparam int RES_W  = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        opcode,
    input logic [RES_W-1:0]  inj_flip,
    input logic [RES_W-1:0]  result_q,
    input logic              err_q,
    input logic              valid_q
);

    logic defined_op;
    assign defined_op = (opcode <= 4'd9);

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> valid_q)
        else $error("valid_q did not follow op_valid (R1)");

    p_clean_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && defined_op && (inj_flip == '0)) |=> !err_q)
        else $error("error raised on fault-free operation (R5)");

    p_arith_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode <= 4'd2) && ($countones(inj_flip) == 1)) |=> err_q)
        else $error("single flip in arithmetic result missed (R6)");

    p_parity_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode >= 4'd3) && defined_op && ($countones(inj_flip) == 1)) |=> err_q)
        else $error("single flip in parity-checked result missed (R7)");

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!err_q && !valid_q))
        else $error("flag or valid raised after idle cycle (R8)");

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result_q))
        else $error("result changed after idle cycle (R8)");

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !defined_op) |=> ((result_q == '0) && !err_q))
        else $error("undefined opcode produced output (R9)");

endmodule

bind resparity_alu resparity_alu_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .opcode  (opcode),
    .inj_flip(inj_flip),
    .result_q(result_q),
    .err_q   (err_q),
    .valid_q (valid_q)
);

// File: tb/test_resparity_alu.sv
`timescale 1ns/1ps
module test_resparity_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [15:0] opd_a = 16'h0;
    logic [15:0] opd_b = 16'h0;
    logic [31:0] inj_flip = 32'h0;
    logic [31:0] result_q;
    logic        err_q;
    logic        valid_q;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    resparity_alu i_resparity_alu (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_valid(op_valid),
        .opcode  (opcode),
        .opd_a   (opd_a),
        .opd_b   (opd_b),
        .inj_flip(inj_flip),
        .result_q(result_q),
        .err_q   (err_q),
        .valid_q (valid_q)
    );

    function automatic logic [31:0] model(input logic [3:0] opc, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] d;
        int s;
        logic [15:0] r;
        s = int'(b[3:0]);
        r = 16'h0;
        case (opc)
            4'd0: return {15'h0, {1'b0, a} + {1'b0, b}};
            4'd1: begin
                d = {1'b0, a} - {1'b0, b};
                return {{16{d[16]}}, d[15:0]};
            end
            4'd2: return 32'(a) * 32'(b);
            4'd3: return {16'h0, a & b};
            4'd4: return {16'h0, a | b};
            4'd5: return {16'h0, a ^ b};
            4'd6: return {16'h0, a << s};
            4'd7: return {16'h0, a >> s};
            4'd8: begin
                for (int k = 0; k < 16; k++) r[(k + s) % 16] = a[k];
                return {16'h0, r};
            end
            4'd9: begin
                for (int k = 0; k < 16; k++) r[k] = a[(k + s) % 16];
                return {16'h0, r};
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string res_tag(input logic [3:0] opc);
        if (opc <= 4'd2) return "R1";
        if (opc <= 4'd5) return "R2";
        if (opc <= 4'd7) return "R3";
        if (opc <= 4'd9) return "R4";
        return "R9";
    endfunction

    function automatic logic [15:0] pat(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h0001;
            4: return 16'h000F;
            5: return 16'h1EF2;
            default: return 16'((i * 40503) ^ (i << 7) ^ 16'h5A3C);
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Caller is at a falling edge; drives, then samples at the next falling edge.
    task automatic run_op(input logic [3:0] opc, input logic [15:0] a, input logic [15:0] b,
                          input logic [31:0] flip, input logic exp_err,
                          input string rtag, input string etag);
        logic [31:0] exp_r;
        op_valid = 1'b1;
        opcode   = opc;
        opd_a    = a;
        opd_b    = b;
        inj_flip = flip;
        exp_r    = (opc <= 4'd9) ? (model(opc, a, b) ^ flip) : 32'h0;
        @(negedge clk);
        check32(rtag, result_q, exp_r);
        check1(etag, err_q, exp_err);
        check1("R1 valid", valid_q, 1'b1);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R10: outputs at zero while reset is held
        check32("R10 result", result_q, 32'h0);
        check1("R10 err", err_q, 1'b0);
        check1("R10 valid", valid_q, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: residue 15 folds to 0; add carry into bit 16
        run_op(4'd0, 16'h0005, 16'h000A, 32'h0, 1'b0, "R11 result", "R11 err");
        run_op(4'd0, 16'hFFFF, 16'h0001, 32'h0, 1'b0, "R11 result", "R11 err");
        run_op(4'd0, 16'h1EF2, 16'h0324, 32'h0, 1'b0, "R1 add", "R5 err");
        run_op(4'd1, 16'h0000, 16'h000F, 32'h0, 1'b0, "R1 sub", "R5 err");

        // R1..R5, R9: sweep all opcodes over operand patterns
        for (int i = 0; i < 48; i++) begin
            for (int op = 0; op < 16; op++) begin
                run_op(4'(op), pat(i), pat(i + 11), (op > 9) ? 32'hA5A5_0F0F : 32'h0, 1'b0,
                       res_tag(4'(op)), (op > 9) ? "R9 err" : "R5 err");
            end
        end

        // R3, R4: every shift and rotate amount
        for (int s = 0; s < 16; s++) begin
            for (int op = 6; op < 10; op++) begin
                run_op(4'(op), 16'hB3C5, 16'(s), 32'h0, 1'b0, res_tag(4'(op)), "R5 err");
            end
        end

        // R6, R7: every single-bit flip for every defined opcode
        for (int op = 0; op < 10; op++) begin
            for (int k = 0; k < 32; k++) begin
                run_op(4'(op), pat(k + 6), pat(k + 20), 32'h1 << k, 1'b1,
                       (op <= 2) ? "R6 result" : "R7 result",
                       (op <= 2) ? "R6 err" : "R7 err");
            end
        end

        // R8: idle cycles with flips present keep result and stay quiet
        run_op(4'd2, 16'h1234, 16'h00FF, 32'h0, 1'b0, "R1 mul", "R5 err");
        held = result_q;
        op_valid = 1'b0;
        inj_flip = 32'h0000_0100;
        opcode   = 4'd0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            check32("R8 result hold", result_q, held);
            check1("R8 err", err_q, 1'b0);
            check1("R8 valid", valid_q, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule